// File: doc/BRIEF.md
# Coprocessor Multi-Word Load/Store Sequencer

This block is a test coprocessor that takes part in the coprocessor load and store instructions of a host core. The host presents one beat per cycle. Each beat carries the instruction word, the coprocessor number, a first-beat flag and a load/store direction. The block answers every beat with a handshake code. For loads it writes the incoming words into consecutive registers of a sixteen-entry, 32-bit register file. For stores it puts consecutive register contents on its data output.

The response looks ahead. After the first beat the host learns whether more words follow (increment), whether the next word is the final one (last), or whether the transfer is complete (done). Instruction bit 22 picks a long transfer, whose length is a per-instance count of 2 or 4 words. Otherwise one word moves. The starting register comes from instruction bits 15:12. A per-instance busy-wait can hold off the first beat for a set number of cycles.

Top module: `cop_xfer_seq`

## Requirements
- R1: When `beat_valid` is low or `cp_num` differs from the instance number (default 5), `resp` is idle (7) and no register changes.
- R2: Synchronous active-low reset clears all sixteen registers to zero.
- R3: The accepted first beat of a load answers last (2) when bit 22 is clear and increment (1) when it is set.
- R4: The accepted first beat of a store always answers increment (1).
- R5: A long load (bit 22 set) writes its data beats to consecutive registers, starting at bits 15:12, with the index wrapping modulo 16.
- R6: After each data beat of a long load, the response is done (3) when the count reaches the long length (default 4), last (2) when exactly one word remains, and increment (1) otherwise.
- R7: A short load (bit 22 clear) writes its single data beat to the register named by bits 15:12 and answers done (3).
- R8: A long store outputs consecutive registers on `rdata`, starting at bits 15:12 and wrapping modulo 16. It answers increment (1) on each data beat until the final one, which answers done (3).
- R9: A short store outputs the register named by bits 15:12 on its single data beat and answers done (3).
- R10: While the host holds a first beat, the block answers busy (0) for the configured number of cycles (default 2). It then handles that beat as an accepted first beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| beat_valid | input | 1 | A beat is presented this cycle |
| beat_first | input | 1 | The beat is the first of an instruction |
| is_load | input | 1 | 1 for a load, 0 for a store |
| cp_num | input | 4 | Coprocessor number addressed by the host |
| instr | input | 32 | Instruction word (bit 22 long, bits 15:12 start register) |
| wdata | input | 32 | Load data word |
| rdata | output | 32 | Store data word |
| resp | output | 3 | Handshake: 0 busy, 1 increment, 2 last, 3 done, 7 idle |

## Verification
On a single beat, the register index can wrap from 15 to 0 while the predictive response also moves to last or done. A long load that starts at register 14 provokes this, because its last two words land in registers 0 and 1. A long store that starts at 15 provokes it in the other direction. The outcome is judged on two things together. Each beat must return the expected code. The words read back must sit in the wrapped registers, and no beat may fall past the transfer length.

// File: rtl/cop_xfer_seq.sv
module cop_xfer_seq #(
  parameter int CP_ID       = 5,
  parameter int LONG_WORDS  = 4,
  parameter int WAIT_CYCLES = 2,
  parameter int DW          = 32,
  parameter int NREG        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat_valid,
  input  logic          beat_first,
  input  logic          is_load,
  input  logic [3:0]    cp_num,
  input  logic [31:0]   instr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [2:0]    resp
);
  localparam int IW = $clog2(NREG);
  localparam int CW = $clog2(LONG_WORDS + 1);
  localparam int WW = (WAIT_CYCLES > 0) ? $clog2(WAIT_CYCLES + 1) : 1;
  localparam logic [2:0] R_BUSY = 3'd0, R_INC = 3'd1, R_LAST = 3'd2,
                         R_DONE = 3'd3, R_IDLE = 3'd7;

  logic [DW-1:0] regs [NREG];
  logic [IW-1:0] idx;
  logic [CW-1:0] cnt;
  logic [WW-1:0] wcnt;

  wire          sel     = beat_valid && (cp_num == 4'(CP_ID));
  wire          lng     = instr[22];
  wire [IW-1:0] fidx    = instr[12 +: IW];
  wire [CW:0]   total   = lng ? (CW+1)'(LONG_WORDS) : (CW+1)'(1);
  wire          waiting = sel && beat_first && (wcnt < WW'(WAIT_CYCLES));
  wire          start   = sel && beat_first && !waiting;
  wire          dbeat   = sel && !beat_first;
  wire [IW-1:0] ridx    = lng ? idx : fidx;
  wire [CW:0]   nxt     = {1'b0, cnt} + 1'b1;

  assign rdata = regs[ridx];

  always_comb begin
    if (!sel)                              resp = R_IDLE;
    else if (waiting)                      resp = R_BUSY;
    else if (start)                        resp = (is_load && !lng) ? R_LAST : R_INC;
    else if (!lng)                         resp = R_DONE;
    else if (nxt >= total)                 resp = R_DONE;
    else if (is_load && (nxt + 1'b1) == total) resp = R_LAST;
    else                                   resp = R_INC;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx  <= '0;
      cnt  <= '0;
      wcnt <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      wcnt <= waiting ? wcnt + 1'b1 : '0;
      if (start) begin
        idx <= fidx;
        cnt <= '0;
      end
      if (dbeat) begin
        if (is_load) regs[ridx] <= wdata;
        if (lng) begin
          idx <= idx + 1'b1;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

module cop_xfer_seq_chk #(
  parameter int CP_ID = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        beat_valid,
  input logic        beat_first,
  input logic        is_load,
  input logic [3:0]  cp_num,
  input logic [31:0] instr,
  input logic [2:0]  resp
);
  wire sel = beat_valid && (cp_num == 4'(CP_ID));

  a_r1_idle_when_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> resp == 3'd7);
  a_r4_store_first_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && beat_first && !is_load) |-> (resp == 3'd0 || resp == 3'd1));
  a_r7_short_load_done: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !beat_first && is_load && !instr[22]) |-> resp == 3'd3);
  a_r6_last_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !beat_first && is_load && $past(resp) == 3'd2 && $past(sel && !beat_first))
      |-> resp == 3'd3);
  a_r10_busy_only_first: assert property (@(posedge clk) disable iff (!rst_n)
    resp == 3'd0 |-> (sel && beat_first));
endmodule

bind cop_xfer_seq cop_xfer_seq_chk #(.CP_ID(CP_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_first(beat_first),
  .is_load(is_load), .cp_num(cp_num), .instr(instr), .resp(resp)
);

// File: tb/tb_cop_xfer_seq.sv
module tb_cop_xfer_seq;
  logic        clk = 0, rst_n = 0, beat_valid = 0, beat_first = 0, is_load = 0;
  logic [3:0]  cp_num = 4'd5;
  logic [31:0] instr = '0, wdata = '0, rdata;
  logic [2:0]  resp;
  int checks = 0, fails = 0;

  cop_xfer_seq dut (.*);
  always #5 clk = ~clk;

  typedef struct packed {
    logic [3:0]  req;
    logic        first;
    logic        load;
    logic        lng;
    logic [3:0]  ridx;
    logic [31:0] wd;
    logic [2:0]  er;
    logic        cr;
    logic [31:0] erd;
  } vec_t;

  localparam vec_t TBL [22] = '{
    // R10 busy, R3 long load first, R5/R6 data beats wrapping 14,15,0,1
    '{4'd10,1'b1,1'b1,1'b1,4'd14,32'h0,3'd0,1'b0,32'h0},
    '{4'd10,1'b1,1'b1,1'b1,4'd14,32'h0,3'd0,1'b0,32'h0},
    '{4'd3, 1'b1,1'b1,1'b1,4'd14,32'h0,3'd1,1'b0,32'h0},
    '{4'd6, 1'b0,1'b1,1'b1,4'd14,32'hA000_0000,3'd1,1'b0,32'h0},
    '{4'd6, 1'b0,1'b1,1'b1,4'd14,32'hA000_0001,3'd1,1'b0,32'h0},
    '{4'd6, 1'b0,1'b1,1'b1,4'd14,32'hA000_0002,3'd2,1'b0,32'h0},
    '{4'd6, 1'b0,1'b1,1'b1,4'd14,32'hA000_0003,3'd3,1'b0,32'h0},
    // R3 short load first answers last, R7 single word done
    '{4'd10,1'b1,1'b1,1'b0,4'd3,32'h0,3'd0,1'b0,32'h0},
    '{4'd10,1'b1,1'b1,1'b0,4'd3,32'h0,3'd0,1'b0,32'h0},
    '{4'd3, 1'b1,1'b1,1'b0,4'd3,32'h0,3'd2,1'b0,32'h0},
    '{4'd7, 1'b0,1'b1,1'b0,4'd3,32'hB000_0003,3'd3,1'b0,32'h0},
    // R4 store first, R8/R5 long store from 15 wrapping
    '{4'd10,1'b1,1'b0,1'b1,4'd15,32'h0,3'd0,1'b0,32'h0},
    '{4'd10,1'b1,1'b0,1'b1,4'd15,32'h0,3'd0,1'b0,32'h0},
    '{4'd4, 1'b1,1'b0,1'b1,4'd15,32'h0,3'd1,1'b0,32'h0},
    '{4'd8, 1'b0,1'b0,1'b1,4'd15,32'h0,3'd1,1'b1,32'hA000_0001},
    '{4'd8, 1'b0,1'b0,1'b1,4'd15,32'h0,3'd1,1'b1,32'hA000_0002},
    '{4'd8, 1'b0,1'b0,1'b1,4'd15,32'h0,3'd1,1'b1,32'hA000_0003},
    '{4'd8, 1'b0,1'b0,1'b1,4'd15,32'h0,3'd3,1'b1,32'h0},
    // R9 short store of register 14
    '{4'd10,1'b1,1'b0,1'b0,4'd14,32'h0,3'd0,1'b0,32'h0},
    '{4'd10,1'b1,1'b0,1'b0,4'd14,32'h0,3'd0,1'b0,32'h0},
    '{4'd4, 1'b1,1'b0,1'b0,4'd14,32'h0,3'd1,1'b0,32'h0},
    '{4'd9, 1'b0,1'b0,1'b0,4'd14,32'h0,3'd3,1'b1,32'hA000_0000}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic f, input logic ld, input logic lg,
                       input logic [3:0] ri, input logic [31:0] wd);
    @(negedge clk);
    beat_valid = v; beat_first = f; is_load = ld;
    instr = 32'h0; instr[22] = lg; instr[15:12] = ri; wdata = wd;
    #2;
  endtask

  task automatic read_reg(input logic [3:0] ri, input logic [31:0] exp, input string req);
    for (int k = 0; k < 2; k++) drive(1, 1, 0, 0, ri, 0);
    drive(1, 1, 0, 0, ri, 0);
    drive(1, 0, 0, 0, ri, 0);
    check(rdata == exp, req, rdata, exp);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 idle while nothing presented
    #2 check(resp == 3'd7, "R1", 32'(resp), 32'd7);
    // R2 / R10 reset state read out through a short store, counting busy beats
    drive(1, 1, 0, 0, 4'd7, 0); check(resp == 3'd0, "R10", 32'(resp), 32'd0);
    drive(1, 1, 0, 0, 4'd7, 0); check(resp == 3'd0, "R10", 32'(resp), 32'd0);
    drive(1, 1, 0, 0, 4'd7, 0); check(resp == 3'd1, "R10", 32'(resp), 32'd1);
    drive(1, 0, 0, 0, 4'd7, 0); check(rdata == 32'h0, "R2", rdata, 32'h0);

    foreach (TBL[i]) begin
      drive(1, TBL[i].first, TBL[i].load, TBL[i].lng, TBL[i].ridx, TBL[i].wd);
      check(resp == TBL[i].er, $sformatf("R%0d row %0d resp", TBL[i].req, i), 32'(resp), 32'(TBL[i].er));
      if (TBL[i].cr)
        check(rdata == TBL[i].erd, $sformatf("R%0d row %0d rdata", TBL[i].req, i), rdata, TBL[i].erd);
    end

    // R7 and R5 read-back of the written registers
    read_reg(4'd3, 32'hB000_0003, "R7");
    read_reg(4'd1, 32'hA000_0003, "R5");

    // R1 wrong coprocessor number: idle, and register 3 untouched
    cp_num = 4'd3;
    drive(1, 1, 1, 0, 4'd3, 0); check(resp == 3'd7, "R1", 32'(resp), 32'd7);
    drive(1, 0, 1, 0, 4'd3, 32'hDEAD_BEEF); check(resp == 3'd7, "R1", 32'(resp), 32'd7);
    drive(0, 0, 1, 0, 4'd3, 32'hDEAD_BEEF);
    cp_num = 4'd5;
    drive(0, 0, 1, 0, 4'd3, 32'hDEAD_BEEF); check(resp == 3'd7, "R1", 32'(resp), 32'd7);
    read_reg(4'd3, 32'hB000_0003, "R1");

    // R2 reset after activity clears registers
    @(negedge clk); rst_n = 0; beat_valid = 0;
    @(negedge clk); rst_n = 1;
    read_reg(4'd14, 32'h0, "R2");

    drive(0, 0, 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule